// File: doc/BRIEF.md
# Fault-Injectable SRAM Model

This block is a small synchronous memory of single-bit cells, one cell per address. At run time it can be made to misbehave in one of six classic functional ways, so that a memory self-test engine placed in front of it can be shown to catch real defect classes. Those classes are stuck cells, blocked transitions, three kinds of coupling between two cells, and a crossed address decoder. Only one fault is live at a time. With the fault switched off, the block behaves as an ordinary RAM.

The data side is a single port. A request with the write flag set stores one bit. A request with the flag clear returns the addressed bit one cycle later, with a valid pulse. The fault side carries a kind code, a victim address, an aggressor address and three control bits: the transition direction, the forced or stuck value, and the aggressor state. These inputs are captured every cycle while the enable is low and are frozen once it is high.

A two-state controller governs the fault. In `CS_OPEN` the configuration is loading and no fault acts. In `CS_ARMED` the frozen fault acts. The transition `OPEN->ARMED` is taken on any edge that samples the enable high. The transition `ARMED->OPEN` is taken on any edge that samples it low. A free-running 8-bit LFSR supplies the noise returned by an address that the decoder fault has made unreachable.

Top module: `fault_inject_sram`

## Requirements
- R1: Reset clears every cell, `mem_rvalid` and `mem_rdata`. With no fault armed, a read returns the last value written to that address. It does so on `mem_rdata` one cycle after the request, together with a one-cycle `mem_rvalid` pulse. `mem_rvalid` stays low after write and idle cycles.
- R2: The fault configuration inputs are captured only on edges where `flt_enable` is low. Changes made while the fault is armed and the enable stays high have no effect.
- R3: A fault acts only on requests taken at edges that come after the first edge sampling `flt_enable` high. A request on that first edge behaves fault-free. Once the enable has been sampled low, the memory is a plain RAM again, and the cell contents are kept. Kind codes 0 and 7 mean no fault.
- R4: Stuck-at, kind 1. A read of the victim returns `flt_value`, and a write to the victim stores `flt_value` whatever data was written. Other cells are unaffected.
- R5: Transition fault, kind 2. With `flt_rising`=1, a write that would take the victim from 0 to 1 leaves it at 0, and 1-to-0 writes work. With `flt_rising`=0, a 1-to-0 write is blocked and 0-to-1 writes work.
- R6: Inversion coupling, kind 3. A write that takes the aggressor through the chosen transition (0 to 1 when `flt_rising`=1, 1 to 0 when `flt_rising`=0) inverts the victim. Writes that leave the aggressor unchanged, or move it the other way, leave the victim alone.
- R7: Idempotent coupling, kind 4. A write that takes the aggressor through the chosen transition sets the victim to `flt_value`. Other aggressor writes leave it alone, and the victim can still be written normally.
- R8: State coupling, kind 5. While the aggressor cell holds `flt_aggr_state`, the victim reads as `flt_value`, and that value is stored into the victim cell. A write to the victim cannot change it during that time.
- R9: Address-decoder fault, kind 6. A write to the victim address lands in the aggressor cell, and a write to the aggressor address lands in the victim cell. A read of the aggressor address returns the victim cell. A read of the victim address returns bit 0 of the LFSR of R10.
- R10: The LFSR is 8 bits, resets to 8'hA5 and steps on every clock edge to {q[6:0], q[7]^q[5]^q[4]^q[3]}. It is never all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | input | 1 | Request strobe for this cycle |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | ADDR_W | Cell address |
| mem_wdata | input | 1 | Write data |
| mem_rvalid | output | 1 | Pulses one cycle after a read request |
| mem_rdata | output | 1 | Read data, held between reads |
| flt_enable | input | 1 | Fault enable; configuration loads while low |
| flt_kind | input | 3 | Fault kind code (0 none, 1..6 as in R4..R9, 7 none) |
| flt_victim | input | ADDR_W | Victim cell address |
| flt_aggressor | input | ADDR_W | Aggressor cell address, or the cross-mapped partner for kind 6 |
| flt_rising | input | 1 | Chosen transition: 1 = 0-to-1, 0 = 1-to-0 |
| flt_value | input | 1 | Stuck or forced victim value |
| flt_aggr_state | input | 1 | Aggressor state that triggers state coupling |

## Verification
A wrong controller state shows up on the very next read of the victim. If the block arms one edge early, the read on the enable edge comes back faulted. A configuration that leaks while armed moves the fault to a different address, and the next read of the old victim is clean. A wrong stored cell value stays hidden until that cell is read. So every coupling case is followed by a victim read after each aggressor write, which puts each effect on `mem_rdata` within two cycles of its cause. Decoder noise is compared cycle for cycle against an independent model of the LFSR, so one skipped step or a wrong seed fails the next read of the unreachable address.

// File: rtl/fsram_pkg.sv
package fsram_pkg;

    typedef enum logic [2:0] {
        FK_NONE  = 3'd0,
        FK_STUCK = 3'd1,
        FK_TRANS = 3'd2,
        FK_CFINV = 3'd3,
        FK_CFID  = 3'd4,
        FK_CFST  = 3'd5,
        FK_ADEC  = 3'd6,
        FK_RSVD  = 3'd7
    } fault_kind_e;

    typedef enum logic {
        CS_OPEN  = 1'b0,
        CS_ARMED = 1'b1
    } cfg_state_e;

    typedef struct packed {
        fault_kind_e kind;
        logic        rise;
        logic        value;
        logic        agg_state;
    } fault_mode_t;

    localparam int          NOISE_W    = 8;
    localparam logic [7:0]  NOISE_SEED = 8'hA5;

endpackage

// File: rtl/fsram_cfg_ctrl.sv
module fsram_cfg_ctrl
    import fsram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_en,
    input  fault_mode_t       mode_in,
    input  logic [ADDR_W-1:0] victim_in,
    input  logic [ADDR_W-1:0] aggr_in,
    output logic              armed,
    output fault_mode_t       mode_q,
    output logic [ADDR_W-1:0] victim_q,
    output logic [ADDR_W-1:0] aggr_q
);

    cfg_state_e state_q, state_d;
    logic       load_cfg;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_OPEN:  if (fault_en)  state_d = CS_ARMED;
            CS_ARMED: if (!fault_en) state_d = CS_OPEN;
            default:  state_d = CS_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_OPEN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        armed    = (state_q == CS_ARMED);
        load_cfg = !fault_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '{kind: FK_NONE, rise: 1'b0, value: 1'b0, agg_state: 1'b0};
            victim_q <= '0;
            aggr_q   <= '0;
        end else if (load_cfg) begin
            mode_q   <= mode_in;
            victim_q <= victim_in;
            aggr_q   <= aggr_in;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && fault_en) |=> ($stable(mode_q) && $stable(victim_q) && $stable(aggr_q))); // R2
    AST_ARM_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        fault_en |=> armed); // R3
    AST_DISARM_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_en |=> !armed); // R3

endmodule

// File: rtl/fsram_noise.sv
module fsram_noise
    import fsram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic noise_bit
);

    logic [NOISE_W-1:0] sr_q;
    logic               fb;

    always_comb begin
        fb        = sr_q[7] ^ sr_q[5] ^ sr_q[4] ^ sr_q[3];
        noise_bit = sr_q[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= NOISE_SEED;
        else        sr_q <= {sr_q[NOISE_W-2:0], fb};
    end

    AST_NOISE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0); // R10

endmodule

// File: rtl/fsram_array.sv
module fsram_array
    import fsram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  fault_mode_t       mode,
    input  logic [ADDR_W-1:0] victim,
    input  logic [ADDR_W-1:0] aggr,
    input  logic              noise_bit,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              rd_valid,
    output logic              rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0]  cells_q, cells_d;
    fault_kind_e       act_kind;
    logic              wr_en, rd_en;
    logic [ADDR_W-1:0] wr_tgt;
    logic              wr_val;
    logic              agg_edge;
    logic              rd_bit;

    always_comb begin
        act_kind = armed ? mode.kind : FK_NONE;
        wr_en    = req_valid && req_write;
        rd_en    = req_valid && !req_write;
        agg_edge = wr_en && (req_addr == aggr) &&
                   (cells_q[aggr] != req_wdata) && (req_wdata == mode.rise);
    end

    // write path: decode, data bend, then coupling onto the victim
    always_comb begin
        cells_d = cells_q;
        wr_tgt  = req_addr;
        wr_val  = req_wdata;
        unique case (act_kind)
            FK_STUCK: begin
                if (req_addr == victim) wr_val = mode.value;
            end
            FK_TRANS: begin
                if ((req_addr == victim) && (cells_q[victim] != req_wdata) &&
                    (req_wdata == mode.rise))
                    wr_val = cells_q[victim];
            end
            FK_ADEC: begin
                if (req_addr == victim)    wr_tgt = aggr;
                else if (req_addr == aggr) wr_tgt = victim;
            end
            default: begin
                wr_tgt = req_addr;
            end
        endcase
        if (wr_en) cells_d[wr_tgt] = wr_val;
        unique case (act_kind)
            FK_CFINV: begin
                if (agg_edge) cells_d[victim] = ~cells_q[victim];
            end
            FK_CFID: begin
                if (agg_edge) cells_d[victim] = mode.value;
            end
            FK_CFST: begin
                if (cells_d[aggr] == mode.agg_state) cells_d[victim] = mode.value;
            end
            default: begin
                cells_d[victim] = cells_d[victim];
            end
        endcase
    end

    // read path
    always_comb begin
        rd_bit = cells_q[req_addr];
        unique case (act_kind)
            FK_STUCK: begin
                if (req_addr == victim) rd_bit = mode.value;
            end
            FK_CFST: begin
                if ((req_addr == victim) && (cells_q[aggr] == mode.agg_state))
                    rd_bit = mode.value;
            end
            FK_ADEC: begin
                if (req_addr == victim)    rd_bit = noise_bit;
                else if (req_addr == aggr) rd_bit = cells_q[victim];
            end
            default: begin
                rd_bit = cells_q[req_addr];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells_q  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= 1'b0;
        end else begin
            cells_q  <= cells_d;
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_bit;
        end
    end

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid); // R1
    AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid); // R1
    AST_STUCK_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mode.kind == FK_STUCK && req_valid && !req_write && req_addr == victim)
        |=> (rd_data == $past(mode.value))); // R4
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> $stable(rd_data)); // R1

endmodule

// File: rtl/fault_inject_sram.sv
module fault_inject_sram
    import fsram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_wdata,
    output logic              mem_rvalid,
    output logic              mem_rdata,
    input  logic              flt_enable,
    input  logic [2:0]        flt_kind,
    input  logic [ADDR_W-1:0] flt_victim,
    input  logic [ADDR_W-1:0] flt_aggressor,
    input  logic              flt_rising,
    input  logic              flt_value,
    input  logic              flt_aggr_state
);

    fault_mode_t       mode_in, mode_q;
    logic              armed;
    logic [ADDR_W-1:0] vic_q, agg_q;
    logic              noise_bit;

    always_comb begin
        mode_in = '{kind: fault_kind_e'(flt_kind), rise: flt_rising,
                    value: flt_value, agg_state: flt_aggr_state};
    end

    fsram_cfg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_en (flt_enable),
        .mode_in  (mode_in),
        .victim_in(flt_victim),
        .aggr_in  (flt_aggressor),
        .armed    (armed),
        .mode_q   (mode_q),
        .victim_q (vic_q),
        .aggr_q   (agg_q)
    );

    fsram_noise u_noise (
        .clk      (clk),
        .rst_n    (rst_n),
        .noise_bit(noise_bit)
    );

    fsram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed),
        .mode     (mode_q),
        .victim   (vic_q),
        .aggr     (agg_q),
        .noise_bit(noise_bit),
        .req_valid(mem_req),
        .req_write(mem_we),
        .req_addr (mem_addr),
        .req_wdata(mem_wdata),
        .rd_valid (mem_rvalid),
        .rd_data  (mem_rdata)
    );

endmodule

// File: tb/tb_fault_inject_sram.sv
`timescale 1ns/1ps
module tb_fault_inject_sram;

    localparam int AW = 4;

    typedef struct packed {
        logic       wr;
        logic [3:0] addr;
        logic       d;
    } vec_t;

    // R1: plain RAM traffic; for reads d is the expected data
    localparam vec_t VEC [0:15] = '{
        '{1'b1, 4'd0,  1'b1}, '{1'b1, 4'd15, 1'b1}, '{1'b1, 4'd5, 1'b0},
        '{1'b1, 4'd8,  1'b1}, '{1'b0, 4'd0,  1'b1}, '{1'b0, 4'd15, 1'b1},
        '{1'b0, 4'd5,  1'b0}, '{1'b0, 4'd8,  1'b1}, '{1'b1, 4'd0,  1'b0},
        '{1'b0, 4'd0,  1'b0}, '{1'b0, 4'd15, 1'b1}, '{1'b1, 4'd5,  1'b1},
        '{1'b0, 4'd5,  1'b1}, '{1'b1, 4'd5,  1'b0}, '{1'b0, 4'd2,  1'b0},
        '{1'b0, 4'd5,  1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_req = 1'b0, mem_we = 1'b0, mem_wdata = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic          mem_rvalid, mem_rdata;
    logic          flt_enable = 1'b0;
    logic [2:0]    flt_kind = 3'd0;
    logic [AW-1:0] flt_victim = '0, flt_aggressor = '0;
    logic          flt_rising = 1'b0, flt_value = 1'b0, flt_aggr_state = 1'b0;
    logic [7:0]    tb_noise;
    int            checks = 0;
    int            errors = 0;

    always #2 clk = ~clk;

    // R10: independent noise model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_noise <= 8'hA5;
        else        tb_noise <= {tb_noise[6:0], tb_noise[7] ^ tb_noise[5] ^ tb_noise[4] ^ tb_noise[3]};
    end

    fault_inject_sram #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .flt_enable(flt_enable), .flt_kind(flt_kind),
        .flt_victim(flt_victim), .flt_aggressor(flt_aggressor),
        .flt_rising(flt_rising), .flt_value(flt_value), .flt_aggr_state(flt_aggr_state)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // all ops start and end on a falling edge
    task automatic wr(input int a, input logic d);
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = a[AW-1:0]; mem_wdata = d;
        @(negedge clk);
        mem_req = 1'b0; mem_we = 1'b0;
    endtask

    task automatic rd(input int a, input logic exp, input string tag, input bit noisy = 1'b0);
        logic e;
        e = noisy ? tb_noise[0] : exp;
        mem_req = 1'b1; mem_we = 1'b0; mem_addr = a[AW-1:0];
        @(negedge clk);
        mem_req = 1'b0;
        chk(tag, mem_rdata, e);
    endtask

    task automatic arm(input int k, input int v, input int a, input logic r,
                       input logic val, input logic y);
        flt_enable = 1'b0;
        flt_kind = k[2:0]; flt_victim = v[AW-1:0]; flt_aggressor = a[AW-1:0];
        flt_rising = r; flt_value = val; flt_aggr_state = y;
        @(negedge clk);
        flt_enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic disarm;
        flt_enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        checks++; errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset rvalid", mem_rvalid, 1'b0);
        chk("R1 reset rdata", mem_rdata, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3, 1'b0, "R1 cell cleared by reset");

        // R1 table walk
        foreach (VEC[i]) begin
            if (VEC[i].wr) begin
                wr(VEC[i].addr, VEC[i].d);
                chk("R1 no rvalid after write", mem_rvalid, 1'b0);
            end else begin
                rd(VEC[i].addr, VEC[i].d, "R1 table read");
                chk("R1 rvalid pulse", mem_rvalid, 1'b1);
            end
        end
        @(negedge clk);
        chk("R1 rvalid idle low", mem_rvalid, 1'b0);
        chk("R1 rdata held", mem_rdata, 1'b0);

        // R3 / R4 / R2: stuck-at-0 on cell 3
        wr(3, 1'b1);
        flt_kind = 3'd1; flt_victim = 4'd3; flt_value = 1'b0;
        @(negedge clk);
        flt_enable = 1'b1;
        rd(3, 1'b1, "R3 first enable edge is fault-free");
        rd(3, 1'b0, "R4 stuck read");
        wr(3, 1'b1);
        rd(3, 1'b0, "R4 stuck after write 1");
        rd(4, 1'b0, "R4 neighbour read");
        wr(4, 1'b1);
        rd(4, 1'b1, "R4 neighbour write");
        wr(4, 1'b0);
        flt_victim = 4'd4; flt_value = 1'b1;
        rd(3, 1'b0, "R2 old victim still stuck");
        rd(4, 1'b0, "R2 new victim ignored");
        disarm();
        rd(3, 1'b0, "R4 stuck value stored");
        wr(3, 1'b1);
        rd(3, 1'b1, "R3 plain RAM after disable");

        // R5 transition faults on cell 1
        arm(2, 1, 0, 1'b1, 1'b0, 1'b0);
        wr(1, 1'b1);
        rd(1, 1'b0, "R5 rise blocked");
        disarm();
        wr(1, 1'b1);
        arm(2, 1, 0, 1'b1, 1'b0, 1'b0);
        wr(1, 1'b0);
        rd(1, 1'b0, "R5 fall works in rise mode");
        arm(2, 1, 0, 1'b0, 1'b0, 1'b0);
        wr(1, 1'b1);
        rd(1, 1'b1, "R5 rise works in fall mode");
        wr(1, 1'b0);
        rd(1, 1'b1, "R5 fall blocked");
        disarm();

        // R6 inversion coupling: victim 2, aggressor 9, rising
        arm(3, 2, 9, 1'b1, 1'b0, 1'b0);
        wr(9, 1'b1);
        rd(2, 1'b1, "R6 rise inverts victim");
        wr(9, 1'b1);
        rd(2, 1'b1, "R6 no transition no effect");
        wr(9, 1'b0);
        rd(2, 1'b1, "R6 opposite transition no effect");
        wr(9, 1'b1);
        rd(2, 1'b0, "R6 second inversion");
        rd(9, 1'b1, "R6 aggressor stores normally");
        disarm();

        // R7 idempotent coupling: victim 4, aggressor 7, falling, force 1
        wr(7, 1'b1);
        arm(4, 4, 7, 1'b0, 1'b1, 1'b0);
        wr(7, 1'b0);
        rd(4, 1'b1, "R7 fall forces victim");
        wr(4, 1'b0);
        rd(4, 1'b0, "R7 victim writable");
        wr(7, 1'b1);
        rd(4, 1'b0, "R7 rise no effect");
        wr(7, 1'b0);
        rd(4, 1'b1, "R7 fall forces again");
        disarm();

        // R8 state coupling: victim 10, aggressor 11, y=1, x=0
        wr(10, 1'b1);
        arm(5, 10, 11, 1'b0, 1'b0, 1'b1);
        rd(10, 1'b1, "R8 inactive state no force");
        wr(11, 1'b1);
        rd(10, 1'b0, "R8 aggressor state forces victim");
        wr(10, 1'b1);
        rd(10, 1'b0, "R8 victim write overridden");
        wr(11, 1'b0);
        rd(10, 1'b0, "R8 forced value stored");
        wr(10, 1'b1);
        rd(10, 1'b1, "R8 victim free again");
        disarm();

        // R9 / R10 decoder fault: victim 5, partner 6
        arm(6, 5, 6, 1'b0, 1'b0, 1'b0);
        wr(5, 1'b1);
        rd(6, 1'b0, "R9 aggressor address reads victim cell");
        wr(6, 1'b1);
        rd(6, 1'b1, "R9 aggressor write lands in victim cell");
        rd(5, 1'b0, "R10 noise read 1", 1'b1);
        rd(5, 1'b0, "R10 noise read 2", 1'b1);
        @(negedge clk);
        rd(5, 1'b0, "R10 noise read 3", 1'b1);
        disarm();
        rd(6, 1'b1, "R9 victim address write landed in cell 6");
        rd(5, 1'b1, "R9 cell 5 holds cross write");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule